// File: doc/BRIEF.md
# Standard-Definition Sync Timing Generator

This block produces the raster timing for a standard-definition video encoder. A horizontal pixel-clock counter and a half-line counter run freely over one frame. An external trigger pulse realigns both counters: it loads the horizontal counter with a programmable horizontal offset and the half-line counter with a programmable vertical offset. A larger offset puts the counters further into the raster, so every timing output that follows the trigger arrives sooner.

The block decodes the counters into five outputs:
- a horizontal sync pulse,
- a vertical sync pulse at the head of each field,
- a field identifier,
- a one-clock strobe at the start of each line,
- a blanking flag.

A mode bit selects between two raster formats. A force bit holds the blanking flag high, so the video path outputs blanking level, while sync, field and line timing keep running unchanged. Configuration is written one byte at a time through a small register port.

Top module: `sd_sync_gen`

## Requirements
- R1: While reset is asserted and until the first counted clock, the outputs show counter state zero: `line_start_o`=1, `hsync_o`=1, `vsync_o`=1, `field_o`=0, `blank_o`=1. The configuration resets to offsets 0, the long format and force off.
- R2: Mode register (address 2) bit 0 selects the line length. When the bit is 1 a line is LEN_SHORT clocks (default 1716). When it is 0 a line is LEN_LONG clocks (default 1728). `line_start_o` is high for exactly one clock per line, while the horizontal count is zero.
- R3: The 11-bit horizontal offset takes its low 8 bits from address 0 and its high 3 bits from bits 7:5 of address 1.
- R4: A byte write that would make the horizontal offset larger than the current line length minus one is ignored, and the previous offset is kept. The vertical offset bits in the same write still take effect.
- R5: A trigger sampled high loads the horizontal counter with the horizontal offset and the half-line counter with the vertical offset (address 1 bits 4:0). With offset H > 0, the next `line_start_o` therefore appears line-length minus H clocks after the loading edge.
- R6: The half-line counter advances when the horizontal count leaves the middle of a line (half line length minus one) and when it leaves the end of a line. It wraps after HL_SHORT (default 1050) or HL_LONG (default 1250) half lines, matching the selected format.
- R7: `hsync_o` is high while the horizontal count is below HSYNC_LEN.
- R8: `field_o` is 0 in the first half of the frame's half lines and 1 from half-frame onward, so it toggles at each field's starting half line.
- R9: `vsync_o` is high during the first VSYNC_HL half lines of each field.
- R10: `blank_o` is high while the horizontal count is below HBLANK_LEN, or while the half line within the field is below VBLANK_HL.
- R11: Mode register bit 1 forces `blank_o` high. Sync, field and line-start outputs are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register byte write strobe |
| wr_addr | input | 2 | Register address (0 offset low, 1 offset high and vertical, 2 mode) |
| wr_data | input | 8 | Register write data |
| trig_in | input | 1 | External timing trigger, active high |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| field_o | output | 1 | Field identifier |
| line_start_o | output | 1 | One-clock strobe at line start |
| blank_o | output | 1 | Blanking flag |

## Verification
The bench runs the block with a shrunken raster, so that many frames, both formats and fields that start mid-line all fit in a short run. A reference model tracks every output on every clock.

Directed checks measure the delay from a trigger to the next line start. A design that loads the wrong bytes, or that clamps instead of rejecting an offset, shows a wrong delay. One offset is accepted in the long format and must be refused in the short one, which exposes a range check tied to the wrong format.

Further checks catch three other faults:
- A half-line counter stepped only once per line, or wrapped at the wrong count, moves the field and vsync edges.
- A vertical offset loaded into the wrong counter does the same.
- A force bit that gates sync instead of blanking breaks the hsync comparison during the forced frame.

// File: rtl/sd_sync_pkg.sv
package sd_sync_pkg;

  localparam int HTRIG_W = 11;
  localparam int VTRIG_W = 5;

  typedef enum logic [1:0] {
    REG_HOFS_LO = 2'd0,
    REG_OFS_HI  = 2'd1,
    REG_MODE    = 2'd2
  } reg_addr_e;

  localparam int MODE_SHORT_BIT = 0;
  localparam int MODE_FORCE_BIT = 1;

  typedef struct packed {
    logic [HTRIG_W-1:0] hofs;
    logic [VTRIG_W-1:0] vofs;
    logic               len_short;
    logic               force_blank;
  } cfg_t;

endpackage

// File: rtl/ssg_rst_sync.sv
module ssg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/ssg_cfg_regs.sv
module ssg_cfg_regs
  import sd_sync_pkg::*;
#(
  parameter int LEN_LONG  = 1728,
  parameter int LEN_SHORT = 1716
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  output cfg_t       cfg_o
);

  localparam logic [HTRIG_W-1:0] LONG_MAX  = HTRIG_W'(LEN_LONG - 1);
  localparam logic [HTRIG_W-1:0] SHORT_MAX = HTRIG_W'(LEN_SHORT - 1);

  cfg_t               cfg_q;
  cfg_t               cfg_d;
  logic               cfg_en;
  logic [HTRIG_W-1:0] hofs_max;
  logic [HTRIG_W-1:0] hofs_cand;

  assign cfg_en   = wr_en;
  assign hofs_max = cfg_q.len_short ? SHORT_MAX : LONG_MAX;

  always_comb begin
    cfg_d     = cfg_q;
    hofs_cand = cfg_q.hofs;
    case (wr_addr)
      REG_HOFS_LO: begin
        hofs_cand = {cfg_q.hofs[HTRIG_W-1:8], wr_data};
        if (hofs_cand <= hofs_max) begin
          cfg_d.hofs = hofs_cand;
        end
      end
      REG_OFS_HI: begin
        hofs_cand  = {wr_data[7:5], cfg_q.hofs[7:0]};
        cfg_d.vofs = wr_data[VTRIG_W-1:0];
        if (hofs_cand <= hofs_max) begin
          cfg_d.hofs = hofs_cand;
        end
      end
      REG_MODE: begin
        cfg_d.len_short   = wr_data[MODE_SHORT_BIT];
        cfg_d.force_blank = wr_data[MODE_FORCE_BIT];
      end
      default: begin
        cfg_d = cfg_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/ssg_counters.sv
module ssg_counters #(
  parameter int LEN_LONG  = 1728,
  parameter int LEN_SHORT = 1716,
  parameter int HL_LONG   = 1250,
  parameter int HL_SHORT  = 1050,
  parameter int HCNT_W    = 11,
  parameter int HL_W      = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic              len_short,
  input  logic [HCNT_W-1:0] hofs,
  input  logic [HL_W-1:0]   vofs,
  output logic [HCNT_W-1:0] hcnt_o,
  output logic [HL_W-1:0]   hl_o
);

  localparam logic [HCNT_W-1:0] LONG_END   = HCNT_W'(LEN_LONG - 1);
  localparam logic [HCNT_W-1:0] SHORT_END  = HCNT_W'(LEN_SHORT - 1);
  localparam logic [HCNT_W-1:0] LONG_MID   = HCNT_W'(LEN_LONG / 2 - 1);
  localparam logic [HCNT_W-1:0] SHORT_MID  = HCNT_W'(LEN_SHORT / 2 - 1);
  localparam logic [HL_W-1:0]   LONG_HLEND = HL_W'(HL_LONG - 1);
  localparam logic [HL_W-1:0]   SHORT_HLEND= HL_W'(HL_SHORT - 1);

  logic [HCNT_W-1:0] hcnt_q, hcnt_d;
  logic [HL_W-1:0]   hl_q, hl_d;
  logic [HCNT_W-1:0] line_end, line_mid;
  logic [HL_W-1:0]   frame_end;
  logic              at_end, hl_step, cnt_en;

  assign cnt_en    = 1'b1;
  assign line_end  = len_short ? SHORT_END : LONG_END;
  assign line_mid  = len_short ? SHORT_MID : LONG_MID;
  assign frame_end = len_short ? SHORT_HLEND : LONG_HLEND;
  assign at_end    = (hcnt_q >= line_end);
  assign hl_step   = at_end || (hcnt_q == line_mid);

  always_comb begin
    if (trig) begin
      hcnt_d = hofs;
      hl_d   = vofs;
    end else begin
      hcnt_d = at_end ? '0 : hcnt_q + 1'b1;
      if (hl_step) begin
        hl_d = (hl_q >= frame_end) ? '0 : hl_q + 1'b1;
      end else begin
        hl_d = hl_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      hl_q   <= '0;
    end else if (cnt_en) begin
      hcnt_q <= hcnt_d;
      hl_q   <= hl_d;
    end
  end

  assign hcnt_o = hcnt_q;
  assign hl_o   = hl_q;

endmodule

// File: rtl/ssg_decode.sv
module ssg_decode #(
  parameter int HL_LONG    = 1250,
  parameter int HL_SHORT   = 1050,
  parameter int HSYNC_LEN  = 127,
  parameter int HBLANK_LEN = 244,
  parameter int VSYNC_HL   = 6,
  parameter int VBLANK_HL  = 40,
  parameter int HCNT_W     = 11,
  parameter int HL_W       = 11
) (
  input  logic [HCNT_W-1:0] hcnt,
  input  logic [HL_W-1:0]   hl,
  input  logic              len_short,
  input  logic              force_blank,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              field_o,
  output logic              line_start_o,
  output logic              blank_o
);

  localparam logic [HL_W-1:0]   LONG_F2   = HL_W'(HL_LONG / 2);
  localparam logic [HL_W-1:0]   SHORT_F2  = HL_W'(HL_SHORT / 2);
  localparam logic [HCNT_W-1:0] HSYNC_END = HCNT_W'(HSYNC_LEN);
  localparam logic [HCNT_W-1:0] HBLK_END  = HCNT_W'(HBLANK_LEN);
  localparam logic [HL_W-1:0]   VSYNC_END = HL_W'(VSYNC_HL);
  localparam logic [HL_W-1:0]   VBLK_END  = HL_W'(VBLANK_HL);

  logic [HL_W-1:0] f2_start;
  logic [HL_W-1:0] hl_in_field;
  logic            second_field;
  logic            hblank, vblank;

  assign f2_start     = len_short ? SHORT_F2 : LONG_F2;
  assign second_field = (hl >= f2_start);
  assign hl_in_field  = second_field ? (hl - f2_start) : hl;
  assign hblank       = (hcnt < HBLK_END);
  assign vblank       = (hl_in_field < VBLK_END);

  assign hsync_o      = (hcnt < HSYNC_END);
  assign line_start_o = (hcnt == '0);
  assign field_o      = second_field;
  assign vsync_o      = (hl_in_field < VSYNC_END);
  assign blank_o      = force_blank || hblank || vblank;

endmodule

// File: rtl/sd_sync_gen.sv
module sd_sync_gen
  import sd_sync_pkg::*;
#(
  parameter int LEN_LONG   = 1728,
  parameter int LEN_SHORT  = 1716,
  parameter int HL_LONG    = 1250,
  parameter int HL_SHORT   = 1050,
  parameter int HSYNC_LEN  = 127,
  parameter int HBLANK_LEN = 244,
  parameter int VSYNC_HL   = 6,
  parameter int VBLANK_HL  = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       trig_in,
  output logic       hsync_o,
  output logic       vsync_o,
  output logic       field_o,
  output logic       line_start_o,
  output logic       blank_o
);

  localparam int HCNT_W = $clog2(LEN_LONG);
  localparam int HL_W   = $clog2(HL_LONG);

  logic              rst_sync_n;
  cfg_t              cfg_q;
  logic [HCNT_W-1:0] hofs_load;
  logic [HL_W-1:0]   vofs_load;
  logic [HCNT_W-1:0] hcnt_q;
  logic [HL_W-1:0]   hl_q;

  ssg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ssg_cfg_regs #(
    .LEN_LONG  (LEN_LONG),
    .LEN_SHORT (LEN_SHORT)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cfg_o   (cfg_q)
  );

  assign hofs_load = HCNT_W'(cfg_q.hofs);
  assign vofs_load = HL_W'(cfg_q.vofs);

  ssg_counters #(
    .LEN_LONG  (LEN_LONG),
    .LEN_SHORT (LEN_SHORT),
    .HL_LONG   (HL_LONG),
    .HL_SHORT  (HL_SHORT),
    .HCNT_W    (HCNT_W),
    .HL_W      (HL_W)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .trig      (trig_in),
    .len_short (cfg_q.len_short),
    .hofs      (hofs_load),
    .vofs      (vofs_load),
    .hcnt_o    (hcnt_q),
    .hl_o      (hl_q)
  );

  ssg_decode #(
    .HL_LONG    (HL_LONG),
    .HL_SHORT   (HL_SHORT),
    .HSYNC_LEN  (HSYNC_LEN),
    .HBLANK_LEN (HBLANK_LEN),
    .VSYNC_HL   (VSYNC_HL),
    .VBLANK_HL  (VBLANK_HL),
    .HCNT_W     (HCNT_W),
    .HL_W       (HL_W)
  ) u_dec (
    .hcnt         (hcnt_q),
    .hl           (hl_q),
    .len_short    (cfg_q.len_short),
    .force_blank  (cfg_q.force_blank),
    .hsync_o      (hsync_o),
    .vsync_o      (vsync_o),
    .field_o      (field_o),
    .line_start_o (line_start_o),
    .blank_o      (blank_o)
  );

endmodule

// File: rtl/sd_sync_gen_chk.sv
module sd_sync_gen_chk #(
  parameter int LEN_LONG  = 1728,
  parameter int LEN_SHORT = 1716,
  parameter int HCNT_W    = 11,
  parameter int HL_W      = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig_in,
  input logic [10:0]       hofs_i,
  input logic [4:0]        vofs_i,
  input logic              len_short_i,
  input logic              force_i,
  input logic [HCNT_W-1:0] hcnt_i,
  input logic [HL_W-1:0]   hl_i,
  input logic              line_start_o,
  input logic              blank_o,
  input logic              field_o
);

  logic [HCNT_W-1:0] c_line_end;
  logic [HCNT_W-1:0] c_line_mid;
  logic [10:0]       c_hofs_max;

  assign c_line_end = len_short_i ? HCNT_W'(LEN_SHORT - 1) : HCNT_W'(LEN_LONG - 1);
  assign c_line_mid = len_short_i ? HCNT_W'(LEN_SHORT / 2 - 1) : HCNT_W'(LEN_LONG / 2 - 1);
  assign c_hofs_max = len_short_i ? 11'(LEN_SHORT - 1) : 11'(LEN_LONG - 1);

  AST_TRIG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    trig_in |=> (hcnt_i == HCNT_W'($past(hofs_i)) && hl_i == HL_W'($past(vofs_i)))); // R5

  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_in && hcnt_i == c_line_end) |=> line_start_o); // R2

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start_o && !trig_in) |=> !line_start_o); // R2

  AST_HOFS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (hofs_i != $past(hofs_i)) |-> (hofs_i <= $past(c_hofs_max))); // R4

  AST_FORCE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    force_i |-> blank_o); // R11

  AST_FIELD_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(field_o) |-> !$stable(hl_i)); // R8

  AST_HL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_in && hcnt_i != c_line_mid && hcnt_i < c_line_end) |=> $stable(hl_i)); // R6

endmodule

bind sd_sync_gen sd_sync_gen_chk #(
  .LEN_LONG  (LEN_LONG),
  .LEN_SHORT (LEN_SHORT),
  .HCNT_W    (HCNT_W),
  .HL_W      (HL_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .trig_in      (trig_in),
  .hofs_i       (cfg_q.hofs),
  .vofs_i       (cfg_q.vofs),
  .len_short_i  (cfg_q.len_short),
  .force_i      (cfg_q.force_blank),
  .hcnt_i       (hcnt_q),
  .hl_i         (hl_q),
  .line_start_o (line_start_o),
  .blank_o      (blank_o),
  .field_o      (field_o)
);

// File: tb/sd_sync_gen_tb_top.sv
module sd_sync_gen_tb_top;

  localparam int LL = 48, LS = 40, HLL = 26, HLS = 22;
  localparam int HSL = 4, HBL = 8, VSL = 2, VBL = 4;

  typedef struct packed {
    logic hs, vs, fld, ls, bl;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       trig_in = 1'b0;
  logic       hsync_o, vsync_o, field_o, line_start_o, blank_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  exp_t exp_q[$];

  int m_hcnt, m_hl, m_hofs, m_vofs, m_short, m_force;
  bit [1:0] m_sync;

  sd_sync_gen #(
    .LEN_LONG(LL), .LEN_SHORT(LS), .HL_LONG(HLL), .HL_SHORT(HLS),
    .HSYNC_LEN(HSL), .HBLANK_LEN(HBL), .VSYNC_HL(VSL), .VBLANK_HL(VBL)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .trig_in(trig_in), .hsync_o(hsync_o),
    .vsync_o(vsync_o), .field_o(field_o), .line_start_o(line_start_o),
    .blank_o(blank_o)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_hcnt = 0; m_hl = 0; m_hofs = 0; m_vofs = 0; m_short = 0; m_force = 0;
  endtask

  function automatic exp_t model_out();
    exp_t e;
    int f2, rel;
    f2 = (m_short != 0 ? HLS : HLL) / 2;
    rel = (m_hl >= f2) ? m_hl - f2 : m_hl;
    e.hs  = (m_hcnt < HSL);
    e.vs  = (rel < VSL);
    e.fld = (m_hl >= f2);
    e.ls  = (m_hcnt == 0);
    e.bl  = (m_force != 0) || (m_hcnt < HBL) || (rel < VBL);
    return e;
  endfunction

  // model: push expected outputs for the state now visible, then advance it
  always @(negedge clk) begin
    int len, frame, nh, nl, nofs, nvofs, nshort, nforce, cand;
    if (!rst_n) begin
      model_reset();
      m_sync = 2'b00;
    end
    exp_q.push_back(model_out());
    len = (m_short != 0) ? LS : LL;
    frame = (m_short != 0) ? HLS : HLL;
    nh = m_hcnt; nl = m_hl; nofs = m_hofs; nvofs = m_vofs;
    nshort = m_short; nforce = m_force;
    if (m_sync[1]) begin
      if (trig_in) begin
        nh = m_hofs; nl = m_vofs;
      end else begin
        nh = (m_hcnt >= len - 1) ? 0 : m_hcnt + 1;
        if (m_hcnt == len / 2 - 1 || m_hcnt >= len - 1)
          nl = (m_hl >= frame - 1) ? 0 : m_hl + 1;
      end
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin
            cand = (m_hofs & 'h700) | int'(wr_data);
            if (cand <= len - 1) nofs = cand;
          end
          2'd1: begin
            cand = (int'(wr_data[7:5]) << 8) | (m_hofs & 'hFF);
            if (cand <= len - 1) nofs = cand;
            nvofs = int'(wr_data[4:0]);
          end
          2'd2: begin
            nshort = int'(wr_data[0]); nforce = int'(wr_data[1]);
          end
          default: ;
        endcase
      end
    end
    if (rst_n) m_sync = {m_sync[0], 1'b1};
    m_hcnt = nh; m_hl = nl; m_hofs = nofs; m_vofs = nvofs;
    m_short = nshort; m_force = nforce;
  end

  // monitor: pop expected items and compare against the outputs
  always @(negedge clk) begin
    #1;
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check("R7 hsync", int'(hsync_o), int'(e.hs));
      check("R6/R9 vsync", int'(vsync_o), int'(e.vs));
      check("R6/R8 field", int'(field_o), int'(e.fld));
      check("R2/R5 line_start", int'(line_start_o), int'(e.ls));
      check("R10/R11 blank", int'(blank_o), int'(e.bl));
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic pulse_trig();
    trig_in = 1'b1;
    tick();
    trig_in = 1'b0;
  endtask

  task automatic trig_delay(input string req, input int exp);
    int n;
    pulse_trig();
    n = 0;
    forever begin
      @(negedge clk);
      if (line_start_o) break;
      n++;
    end
    check(req, n, exp);
  endtask

  task automatic line_period(input string req, input int exp);
    int n;
    do @(negedge clk); while (!line_start_o);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!line_start_o);
    check(req, n, exp);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int blank_low;
    #1 rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R1: reset view of counter state zero
    check("R1 line_start", int'(line_start_o), 1);
    check("R1 hsync", int'(hsync_o), 1);
    check("R1 vsync", int'(vsync_o), 1);
    check("R1 field", int'(field_o), 0);
    check("R1 blank", int'(blank_o), 1);
    tick();
    rst_n = 1'b1;
    repeat (2 * LL * HLL) tick();
    line_period("R2 long line", LL);

    // R3: offset bytes, 30 low, 0 high, vertical 5
    reg_wr(2'd0, 8'd30);
    reg_wr(2'd1, {3'b000, 5'd5});
    trig_delay("R3/R5 offset 30 delay", LL - 30);
    // R4: high byte would give 286, rejected
    reg_wr(2'd1, {3'b001, 5'd7});
    trig_delay("R4 high byte rejected", LL - 30);
    reg_wr(2'd0, 8'd200);
    trig_delay("R4 low byte rejected", LL - 30);
    reg_wr(2'd0, 8'd45);
    trig_delay("R5 offset 45 long", LL - 45);
    repeat (LL * HLL) tick();

    // R2: short format, 45 now refused
    reg_wr(2'd2, 8'h01);
    line_period("R2 short line", LS);
    reg_wr(2'd0, 8'd30);
    reg_wr(2'd0, 8'd45);
    trig_delay("R4 offset 45 refused short", LS - 30);
    reg_wr(2'd1, {3'b000, 5'd10});
    pulse_trig();
    repeat (2 * LS * HLS) tick();

    // R11: force blanking over a full frame
    reg_wr(2'd2, 8'h03);
    blank_low = 0;
    for (int i = 0; i < LS * HLS; i++) begin
      @(negedge clk);
      if (!blank_o) blank_low++;
    end
    check("R11 blank held", blank_low, 0);
    line_period("R11 line timing under force", LS);
    reg_wr(2'd2, 8'h00);
    reg_wr(2'd1, {3'b000, 5'd12});
    pulse_trig();
    repeat (2 * LL * HLL) tick();
    repeat (2) @(negedge clk);
    #2;
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule